// File: doc/BRIEF.md
# Multi-Port Link Heartbeat Monitor

This block watches a set of point-to-point Ethernet links at the same time. Each port has its own tracker with its own timer and state. When a port has seen neither receive nor transmit activity for a programmable number of ticks, its tracker requests a heartbeat probe on that port. It then waits, for a second programmable number of ticks, for a heartbeat reply. If no reply comes, the port is marked failed and an interrupt is raised. A failed port keeps probing at the idle interval, and a valid reply brings it back.

The same trackers also answer probes that arrive from peer devices, by asking the transmit side to send a heartbeat reply on the port the probe came in on. Both timers advance on one shared tick, which a prescaler makes from the clock, so both intervals are given in tick units. Frame building, parsing and the MAC are outside the block. The block only sees activity strobes and decoded heartbeat indications, and it hands out send requests that the transmit side acknowledges.

Top module: `hb_link_monitor`

## Requirements
- R1: After reset, every `send_req` bit, every `fail_status` bit and `irq` are 0.
- R2: A port in the monitoring state that sees no activity raises `send_req` with `send_is_reply`=0 (a probe). This happens when its idle count reaches `idle_limit` ticks. With prescale P and effective limit L (`idle_limit` 0 counts as 1), `send_req` rises between (L-1)·P+2 and L·P+1 clock edges after the last edge that sampled activity.
- R3: A high `rx_act` or `tx_act` bit on a monitoring port restarts that port's idle count. A port with activity more often than its idle interval never probes.
- R4: The reply window starts at the edge that acknowledges the probe. If no reply arrives within `reply_window` ticks (0 counts as 1), `fail_status` goes to 1 between (W-1)·P+1 and W·P edges after that edge.
- R5: A reply (`hb_rx_valid`=1 with `hb_rx_is_reply`=1) on a port that is waiting for one clears that port's failure at the next edge and returns the port to monitoring. A reply on a port that is not waiting has no effect on `fail_status`.
- R6: After a failure, the port goes back to monitoring with a fresh idle count. It probes again within the R2 window, counted from the edge that set the failure.
- R7: A peer probe (`hb_rx_valid`=1 with `hb_rx_is_reply`=0) makes `send_req` go to 1 with `send_is_reply`=1 on the same port. This is seen after the second edge following the edge that sampled the peer probe.
- R8: A raised `send_req` and its `send_is_reply` value hold until `send_ack` is sampled high. Each port has one request out at a time. If a reply and a probe are both pending, the reply is handed out first.
- R9: A `fail_status` bit stays set until a `fail_clr` bit for that port (write-one-to-clear) or a valid reply clears it. A clear takes effect at the next edge.
- R10: `irq` is high exactly when some port has both `fail_status` and `irq_en` set. `irq` follows `irq_en` with no clock delay.
- R11: Ports are independent. Activity, probes or failures on one port do not change another port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | TW | Idle interval in ticks before a probe (0 treated as 1) |
| reply_window | input | TW | Ticks allowed for a reply after a probe is sent (0 treated as 1) |
| rx_act | input | NPORTS | Per-port receive activity strobe |
| tx_act | input | NPORTS | Per-port transmit activity strobe |
| hb_rx_valid | input | NPORTS | Per-port heartbeat frame received |
| hb_rx_is_reply | input | NPORTS | Type of the received heartbeat: 1 reply, 0 request |
| send_ack | input | NPORTS | Per-port acknowledge of the current send request |
| fail_clr | input | NPORTS | Write-one-to-clear pulses for the failure bits |
| irq_en | input | NPORTS | Per-port interrupt enable |
| send_req | output | NPORTS | Per-port heartbeat send request, held until acknowledged |
| send_is_reply | output | NPORTS | Type of the requested frame: 1 reply, 0 probe |
| fail_status | output | NPORTS | Sticky per-port link failure |
| irq | output | 1 | OR of enabled failure bits |

## Verification
There are two kinds of result, and their timing is known in different ways. Results that do not depend on the tick are due at fixed cycles: a peer probe shows up as a send request after the second edge, while a clear, a reply or an acknowledge takes effect after the next edge and the interrupt follows its enable at once. Results that do depend on the tick, the probe and the failure, have an unknown tick phase. For these the bench counts clock edges from the stimulus edge until the output changes, and accepts any count inside the window that R2, R4 and R6 give for that idle limit and reply window. All samples are taken at the falling edge, and the sweeps cover several idle-limit and reply-window pairs, the zero values among them.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {ST_MON, ST_WAIT} hb_state_e;

  // True when one more tick makes the count reach the limit (limit 0 acts as 1).
  function automatic logic hb_reached(input logic [31:0] cnt, input logic [31:0] lim);
    logic [32:0] eff;
    eff = (lim == 32'd0) ? 33'd1 : {1'b0, lim};
    return ({1'b0, cnt} + 33'd1) >= eff;
  endfunction
endpackage

// File: rtl/hb_tick_gen.sv
module hb_tick_gen #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (!rst_n)            pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                   pcnt <= pcnt + PW'(1);
      end
      assign tick = (pcnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/hb_port_tracker.sv
module hb_port_tracker
  import hb_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [TW-1:0] idle_limit,
  input  logic [TW-1:0] reply_window,
  input  logic          act,
  input  logic          hb_valid,
  input  logic          hb_is_reply,
  input  logic          send_ack,
  input  logic          fail_clr,
  output logic          send_req,
  output logic          send_is_reply,
  output logic          fail,
  output logic          reply_ok,
  output logic          fail_set
);
  hb_state_e     state;
  logic [TW-1:0] cnt;
  logic          rep_pend, probe_pend, busy, busy_rep;
  logic          peer_req, probe_inflight, idle_fire, slot_free;
  logic          load, load_rep, load_probe;

  always_comb begin
    reply_ok       = hb_valid & hb_is_reply & (state == ST_WAIT);
    peer_req       = hb_valid & ~hb_is_reply;
    probe_inflight = probe_pend | (busy & ~busy_rep);
    idle_fire      = (state == ST_MON) & ~act & tick &
                     hb_reached(32'(cnt), 32'(idle_limit));
    fail_set       = (state == ST_WAIT) & ~reply_ok & ~probe_inflight & tick &
                     hb_reached(32'(cnt), 32'(reply_window));
    slot_free      = ~busy | send_ack;
    load           = slot_free & (rep_pend | probe_pend);
    load_rep       = load & rep_pend;
    load_probe     = load & ~rep_pend & probe_pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_MON;
      cnt   <= '0;
    end else if (state == ST_MON) begin
      if (act)            cnt <= '0;
      else if (idle_fire) begin
        state <= ST_WAIT;
        cnt   <= '0;
      end else if (tick)  cnt <= cnt + TW'(1);
    end else begin
      if (reply_ok || fail_set) begin
        state <= ST_MON;
        cnt   <= '0;
      end else if (tick && !probe_inflight) cnt <= cnt + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_pend   <= 1'b0;
      probe_pend <= 1'b0;
      busy       <= 1'b0;
      busy_rep   <= 1'b0;
      fail       <= 1'b0;
    end else begin
      rep_pend   <= (rep_pend & ~load_rep) | peer_req;
      probe_pend <= (probe_pend & ~load_probe) | idle_fire;
      if (load) begin
        busy     <= 1'b1;
        busy_rep <= rep_pend;
      end else if (send_ack) begin
        busy     <= 1'b0;
      end
      if (fail_set)                  fail <= 1'b1;
      else if (reply_ok || fail_clr) fail <= 1'b0;
    end
  end

  assign send_req      = busy;
  assign send_is_reply = busy_rep;
endmodule

// File: rtl/hb_link_monitor.sv
module hb_link_monitor #(
  parameter int NPORTS   = 4,
  parameter int TW       = 8,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     idle_limit,
  input  logic [TW-1:0]     reply_window,
  input  logic [NPORTS-1:0] rx_act,
  input  logic [NPORTS-1:0] tx_act,
  input  logic [NPORTS-1:0] hb_rx_valid,
  input  logic [NPORTS-1:0] hb_rx_is_reply,
  input  logic [NPORTS-1:0] send_ack,
  input  logic [NPORTS-1:0] fail_clr,
  input  logic [NPORTS-1:0] irq_en,
  output logic [NPORTS-1:0] send_req,
  output logic [NPORTS-1:0] send_is_reply,
  output logic [NPORTS-1:0] fail_status,
  output logic              irq
);
  logic              tick;
  logic [NPORTS-1:0] reply_ok;
  logic [NPORTS-1:0] fail_set;

  hb_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    hb_port_tracker #(.TW(TW)) trk_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .idle_limit   (idle_limit),
      .reply_window (reply_window),
      .act          (rx_act[p] | tx_act[p]),
      .hb_valid     (hb_rx_valid[p]),
      .hb_is_reply  (hb_rx_is_reply[p]),
      .send_ack     (send_ack[p]),
      .fail_clr     (fail_clr[p]),
      .send_req     (send_req[p]),
      .send_is_reply(send_is_reply[p]),
      .fail         (fail_status[p]),
      .reply_ok     (reply_ok[p]),
      .fail_set     (fail_set[p])
    );
  end

  assign irq = |(fail_status & irq_en);
endmodule

// File: rtl/hb_link_monitor_chk.sv
module hb_link_monitor_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] send_req,
  input logic [NPORTS-1:0] send_is_reply,
  input logic [NPORTS-1:0] send_ack,
  input logic [NPORTS-1:0] fail_status,
  input logic [NPORTS-1:0] fail_clr,
  input logic [NPORTS-1:0] irq_en,
  input logic              irq,
  input logic              tick,
  input logic [NPORTS-1:0] reply_ok,
  input logic [NPORTS-1:0] fail_set
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (send_req[i] && !send_ack[i]) |=> (send_req[i] && $stable(send_is_reply[i])));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_status[i] && !fail_clr[i] && !reply_ok[i]) |=> fail_status[i]);

    assert_fail_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_status[i]) |-> $past(tick));

    assert_reply_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_ok[i] && !fail_set[i]) |=> !fail_status[i]);

    assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_status[i] && irq_en[i]) |-> irq);
  end

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_status & irq_en) == '0) |-> !irq);
endmodule

bind hb_link_monitor hb_link_monitor_chk #(.NPORTS(NPORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_is_reply(send_is_reply),
  .send_ack(send_ack), .fail_status(fail_status), .fail_clr(fail_clr),
  .irq_en(irq_en), .irq(irq), .tick(tick), .reply_ok(reply_ok), .fail_set(fail_set)
);

// File: tb/hb_link_monitor_tb_top.sv
`timescale 1ns/100ps
module hb_link_monitor_tb_top;
  localparam int N  = 2;
  localparam int TW = 6;
  localparam int P  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] idle_limit = TW'(5);
  logic [TW-1:0] reply_window = TW'(3);
  logic rx0 = 0, tx0 = 0, hbv0 = 0, hbr0 = 0, ack0 = 0, clr0 = 0, en0 = 1;
  logic [N-1:0] rx_act, tx_act, hb_rx_valid, hb_rx_is_reply, send_ack, fail_clr, irq_en;
  logic [N-1:0] send_req, send_is_reply, fail_status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  assign rx_act = {1'b0, rx0};
  assign tx_act = {1'b1, tx0};      // port 1 busy every cycle (keeps it alive)
  assign hb_rx_valid = {1'b0, hbv0};
  assign hb_rx_is_reply = {1'b0, hbr0};
  assign send_ack = {1'b0, ack0};
  assign fail_clr = {1'b0, clr0};
  assign irq_en = {1'b1, en0};

  always #2.5 clk = ~clk;

  hb_link_monitor #(.NPORTS(N), .TW(TW), .PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit), .reply_window(reply_window),
    .rx_act(rx_act), .tx_act(tx_act), .hb_rx_valid(hb_rx_valid),
    .hb_rx_is_reply(hb_rx_is_reply), .send_ack(send_ack), .fail_clr(fail_clr),
    .irq_en(irq_en), .send_req(send_req), .send_is_reply(send_is_reply),
    .fail_status(fail_status), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int n, input int lo, input int hi);
    checks++;
    if (n < lo || n > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, n, lo, hi);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // All tasks start and end just after a falling edge.
  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_probe(input string tag, input int l);
    int n = 0;
    while (!send_req[0] && n < 400) begin step(); n++; end
    chk_rng(tag, n, (eff(l) - 1) * P + 2, eff(l) * P + 1);
    chk(send_is_reply[0] == 1'b0, {tag, " probe type"}, send_is_reply[0], 0);
  endtask

  task automatic pulse_act_and_probe(input int l);
    rx0 = 1; step(); rx0 = 0;
    wait_probe("R2 probe delay after activity", l);
  endtask

  task automatic ack_once;
    ack0 = 1; step(); ack0 = 0;
  endtask

  task automatic send_reply;
    hbv0 = 1; hbr0 = 1; step(); hbv0 = 0; hbr0 = 0;
  endtask

  task automatic wait_fail(input int w);
    int n = 0;
    while (!fail_status[0] && n < 400) begin step(); n++; end
    chk_rng("R4 failure delay after ack", n, (eff(w) - 1) * P + 1, eff(w) * P);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lims[4] = '{0, 1, 2, 5};
    int wins[3] = '{0, 1, 3};
    @(negedge clk);
    chk(send_req == '0, "R1 send_req in reset", send_req, 0);
    chk(fail_status == '0 && !irq, "R1 fail/irq in reset", {fail_status, irq}, 0);
    repeat (3) step();
    rst_n = 1;
    step();
    chk(send_req == '0 && fail_status == '0 && !irq, "R1 after reset release",
        {send_req, fail_status, irq}, 0);

    // Sweep of idle limit x reply window on port 0 (R2, R4, R5, R6, R10).
    foreach (lims[a]) begin
      foreach (wins[b]) begin
        idle_limit = TW'(lims[a]);
        reply_window = TW'(wins[b]);
        pulse_act_and_probe(lims[a]);
        ack_once();
        chk(send_req[0] == 1'b0, "R8 request drops after ack", send_req[0], 0);
        wait_fail(wins[b]);
        chk(irq == 1'b1, "R10 irq with enabled failure", irq, 1);
        chk(send_req[1] == 1'b0 && fail_status[1] == 1'b0, "R11 port 1 unaffected",
            {send_req[1], fail_status[1]}, 0);
        wait_probe("R6 reprobe delay after failure", lims[a]);
        ack_once();
        send_reply();
        chk(fail_status[0] == 1'b0, "R5 reply clears failure", fail_status[0], 0);
        chk(irq == 1'b0, "R10 irq drops with failure", irq, 0);
      end
    end

    // R3: frequent activity keeps port 0 from probing.
    idle_limit = TW'(3);
    begin
      int bad = 0;
      for (int k = 0; k < 20; k++) begin
        if (k % 2 == 0) rx0 = 1; else tx0 = 1;
        step(); rx0 = 0; tx0 = 0;
        for (int j = 0; j < 5; j++) begin
          step();
          if (send_req != '0) bad++;
        end
      end
      chk(bad == 0, "R3 no probe while active / R11 port 1 silent", bad, 0);
    end

    // R5 ignored reply, R9 sticky and clear, R10 mask.
    idle_limit = TW'(2);
    reply_window = TW'(1);
    pulse_act_and_probe(2);
    ack_once();
    wait_fail(1);
    send_reply();
    chk(fail_status[0] == 1'b1, "R5 reply while not waiting ignored", fail_status[0], 1);
    step();
    chk(fail_status[0] == 1'b1, "R9 failure sticky", fail_status[0], 1);
    en0 = 0; #1;
    chk(irq == 1'b0, "R10 masked failure gives no irq", irq, 0);
    en0 = 1; #1;
    chk(irq == 1'b1, "R10 unmasked failure gives irq", irq, 1);
    clr0 = 1; step(); clr0 = 0;
    chk(fail_status[0] == 1'b0, "R9 write-one-to-clear", fail_status[0], 0);
    chk(irq == 1'b0, "R10 irq low after clear", irq, 0);
    begin
      int n = 0;
      while (!send_req[0] && n < 100) begin step(); n++; end
    end
    ack_once();
    send_reply();

    // R7 / R8: peer probe answered, held, reply first.
    idle_limit = TW'(63);
    rx0 = 1; step(); rx0 = 0;
    hbv0 = 1; hbr0 = 0; step(); hbv0 = 0;
    chk(send_req[0] == 1'b0, "R7 no request one edge after peer probe", send_req[0], 0);
    step();
    chk(send_req[0] == 1'b1 && send_is_reply[0] == 1'b1, "R7 reply requested",
        {send_req[0], send_is_reply[0]}, 3);
    begin
      int bad = 0;
      for (int k = 0; k < 8; k++) begin
        step();
        if (!(send_req[0] && send_is_reply[0])) bad++;
      end
      chk(bad == 0, "R8 request held until ack", bad, 0);
    end
    hbv0 = 1; hbr0 = 0; step(); hbv0 = 0;
    idle_limit = TW'(1);
    repeat (2 * P + 2) step();
    chk(send_req[0] == 1'b1 && send_is_reply[0] == 1'b1, "R8 first reply still held",
        {send_req[0], send_is_reply[0]}, 3);
    ack_once();
    chk(send_req[0] == 1'b1 && send_is_reply[0] == 1'b1, "R8 pending reply before probe",
        {send_req[0], send_is_reply[0]}, 3);
    ack_once();
    chk(send_req[0] == 1'b1 && send_is_reply[0] == 1'b0, "R8 probe after reply",
        {send_req[0], send_is_reply[0]}, 2);
    ack_once();
    chk(send_req[0] == 1'b0, "R8 idle after last ack", send_req[0], 0);
    send_reply();
    chk(fail_status == '0, "R5 no failure after timely reply", fail_status, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule